// File: doc/BRIEF.md
# Routable Multi-Output Interrupt Controller

This block gathers sixteen interrupt sources and steers each one to one of eight CPU interrupt outputs. Every source has a 4-bit routing field made of a 3-bit destination number and an enable bit. A source raises nothing while its enable bit is clear. Sources 0 to 4 are external lines whose polarity (active high or active low) and trigger style (edge or level) are programmable. Sources 5 to 15 are fixed as active-high, edge-latched inputs. Each raw input passes through a two-flop synchronizer. Polarity is applied before the trigger logic.

Software uses a single-cycle register port. A write lands on the next rising clock edge, and a read returns data combinationally from the address. Edge events are held in a sticky pending bit that a write-one-to-clear register removes. Each output has a 16-bit status view listing the sources that currently point at it. The output pin itself is the registered OR of that view, gated by a per-output enable bit.

Register map (byte addresses):
- 0x00: routing word for sources 0–7.
- 0x04: routing word for sources 8–15.
- 0x08: clear register, write only.
- 0x0C: line configuration.
- 0x10: output enables.
- 0x20–0x2C: status views.

Top module: `irq_steer_top`

## Requirements
- R1: After reset every register reads zero and every output is low.
- R2: Source n's field sits in the routing word at 0x00 (n<8) or 0x04 (n≥8), at bits [4(n mod 8)+3 : 4(n mod 8)]. Field bits [2:0] give the destination output 0–7 and field bit 3 is the enable. Both routing words read back exactly as written.
- R3: A source whose enable bit is 0 sets no bit in any status view and raises no output. Restoring the enable brings back a still-pending source.
- R4: Writing 1 to bit n of the clear register (0x08) removes the latched edge event of source n. Bits written 0 leave their sources unchanged. The clear register reads zero.
- R5: Output k's 16-bit status view lies at byte offset 2k from 0x20, so the word at 0x20+4j returns output 2j+1 in bits [31:16] and output 2j in bits [15:0]. Bit n of a view is set when source n is pending, enabled and routed to that output.
- R6: Output k asserts only while bit 16+k of the output-enable word (0x10) is set. That bit reads back as written. Clearing it drops the output one edge later and leaves the status views unchanged.
- R7: In the line configuration word (0x0C), bit 2i set makes line i (0–4) active low and bit 2i+1 set makes it level-triggered. Both clear means active high and edge-triggered. Bits above 9 read zero.
- R8: In edge mode an active-going transition sets a pending bit. That bit stays set after the line returns inactive, until it is cleared.
- R9: In level mode pending tracks the active level. A clear while the line is active has no lasting effect, and pending drops once the line goes inactive.
- R10: Sources 5 to 15 behave as active-high, edge-latched inputs.
- R11: An input change is visible in the status views after the third rising edge. It reaches the output pin after the fourth rising edge.
- R12: Reads of addresses outside the map return zero.
- R13: Writing zero to both routing words silences every source in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Byte address of the register access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from reg_addr |
| irq_in | input | 16 | Raw asynchronous interrupt sources |
| irq_out | output | 8 | CPU interrupt outputs |

## Verification
Four properties are checked on every cycle:
- No output rises unless its enable bit was set on the previous edge.
- No source shows up in more than one status view.
- A disabled source never appears in any view.
- An edge-mode pending bit never drops without a clear.

Only the bench scenarios can show the following:
- The exact three- and four-edge latency.
- The polarity inversion of active-low lines.
- The way a clear is ignored in level mode.
- The bit packing of the routing fields and the status words.
- The zero returned from unmapped addresses.

// File: rtl/irq_steer_pkg.sv
package irq_steer_pkg;

    localparam int SRC_N   = 16;
    localparam int OUT_N   = 8;
    localparam int CFG_N   = 5;
    localparam int SYNC_N  = 2;
    localparam int ADDR_W  = 8;
    localparam int DATA_W  = 32;

    localparam int DEST_W      = 3;
    localparam int FIELD_W     = DEST_W + 1;
    localparam int FIELDS_PW   = DATA_W / FIELD_W;
    localparam int ROUTE_BASE  = 'h00;
    localparam int CLEAR_ADDR  = 'h08;
    localparam int LINE_ADDR   = 'h0C;
    localparam int OUTEN_ADDR  = 'h10;
    localparam int STAT_BASE   = 'h20;
    localparam int OUTEN_LSB   = 16;

    typedef logic [DEST_W-1:0] dest_t;

    typedef struct packed {
        logic  en;
        dest_t dest;
    } route_t;

    typedef enum logic {
        TRIG_EDGE  = 1'b0,
        TRIG_LEVEL = 1'b1
    } trig_e;

    function automatic logic [ADDR_W-1:0] word_addr(input int base, input int idx);
        return ADDR_W'(base + 4 * idx);
    endfunction

endpackage

// File: rtl/irq_line_cond.sv
module irq_line_cond
    import irq_steer_pkg::*;
#(
    parameter int SYNC_STAGES = SYNC_N
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  raw,
    input  logic  act_low,
    input  trig_e trig,
    input  logic  clr,
    output logic  pending
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;
    logic                   active;

    assign active = sync_q[SYNC_STAGES-1] ^ act_low;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q  <= '0;
            prev_q  <= 1'b0;
            pending <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], raw};
            prev_q <= active;
            if (trig == TRIG_LEVEL)
                pending <= active;
            else if (active && !prev_q)
                pending <= 1'b1;
            else if (clr)
                pending <= 1'b0;
        end
    end
endmodule

// File: rtl/irq_steer_regs.sv
module irq_steer_regs
    import irq_steer_pkg::*;
#(
    parameter int N_SRC = SRC_N,
    parameter int N_OUT = OUT_N,
    parameter int N_CFG = CFG_N,
    parameter int AW    = ADDR_W,
    parameter int DW    = DATA_W
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        we,
    input  logic [AW-1:0]               addr,
    input  logic [DW-1:0]               wdata,
    output logic [DW-1:0]               rdata,
    input  logic [N_OUT-1:0][N_SRC-1:0] stat,
    output route_t [N_SRC-1:0]          route,
    output logic [N_SRC-1:0]            act_low,
    output trig_e [N_SRC-1:0]           trig,
    output logic [N_SRC-1:0]            clr,
    output logic [N_OUT-1:0]            out_en
);
    localparam int CTRL_WORDS = N_SRC / FIELDS_PW;
    localparam int STAT_WORDS = N_OUT / 2;

    logic [CTRL_WORDS-1:0][DW-1:0] ctrl_q;
    logic [2*N_CFG-1:0]            cfg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            cfg_q  <= '0;
            out_en <= '0;
        end else if (we) begin
            for (int w = 0; w < CTRL_WORDS; w++)
                if (addr == word_addr(ROUTE_BASE, w)) ctrl_q[w] <= wdata;
            if (addr == AW'(LINE_ADDR))  cfg_q  <= wdata[2*N_CFG-1:0];
            if (addr == AW'(OUTEN_ADDR)) out_en <= wdata[OUTEN_LSB +: N_OUT];
        end
    end

    assign clr = (we && addr == AW'(CLEAR_ADDR)) ? wdata[N_SRC-1:0] : '0;

    for (genvar n = 0; n < N_SRC; n++) begin : g_src
        assign route[n] = route_t'(ctrl_q[n / FIELDS_PW][(n % FIELDS_PW) * FIELD_W +: FIELD_W]);
        if (n < N_CFG) begin : g_cfg
            assign act_low[n] = cfg_q[2*n];
            assign trig[n]    = trig_e'(cfg_q[2*n+1]);
        end else begin : g_fixed
            assign act_low[n] = 1'b0;
            assign trig[n]    = TRIG_EDGE;
        end
    end

    always_comb begin
        rdata = '0;
        for (int w = 0; w < CTRL_WORDS; w++)
            if (addr == word_addr(ROUTE_BASE, w)) rdata = ctrl_q[w];
        if (addr == AW'(LINE_ADDR))  rdata[2*N_CFG-1:0] = cfg_q;
        if (addr == AW'(OUTEN_ADDR)) rdata[OUTEN_LSB +: N_OUT] = out_en;
        for (int j = 0; j < STAT_WORDS; j++)
            if (addr == word_addr(STAT_BASE, j)) rdata = DW'({stat[2*j+1], stat[2*j]});
    end
endmodule

// File: rtl/irq_steer_fanout.sv
module irq_steer_fanout
    import irq_steer_pkg::*;
#(
    parameter int N_SRC = SRC_N,
    parameter int N_OUT = OUT_N
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [N_SRC-1:0]            pending,
    input  route_t [N_SRC-1:0]          route,
    input  logic [N_OUT-1:0]            out_en,
    output logic [N_OUT-1:0][N_SRC-1:0] stat,
    output logic [N_OUT-1:0]            irq_out
);
    always_comb begin
        for (int k = 0; k < N_OUT; k++)
            for (int n = 0; n < N_SRC; n++)
                stat[k][n] = pending[n] && route[n].en && (route[n].dest == dest_t'(k));
    end

    always_ff @(posedge clk) begin
        if (rst)
            irq_out <= '0;
        else
            for (int k = 0; k < N_OUT; k++)
                irq_out[k] <= (|stat[k]) && out_en[k];
    end
endmodule

// File: rtl/irq_steer_top.sv
module irq_steer_top
    import irq_steer_pkg::*;
#(
    parameter int N_SRC       = SRC_N,
    parameter int N_OUT       = OUT_N,
    parameter int N_CFG       = CFG_N,
    parameter int SYNC_STAGES = SYNC_N,
    parameter int AW          = ADDR_W,
    parameter int DW          = DATA_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_we,
    input  logic [AW-1:0]    reg_addr,
    input  logic [DW-1:0]    reg_wdata,
    output logic [DW-1:0]    reg_rdata,
    input  logic [N_SRC-1:0] irq_in,
    output logic [N_OUT-1:0] irq_out
);
    route_t [N_SRC-1:0]          route;
    logic [N_SRC-1:0]            act_low;
    trig_e [N_SRC-1:0]           trig;
    logic [N_SRC-1:0]            clr_vec;
    logic [N_SRC-1:0]            pending;
    logic [N_SRC-1:0]            src_en;
    logic [N_SRC-1:0]            lvl_mode;
    logic [N_OUT-1:0]            out_en;
    logic [N_OUT-1:0][N_SRC-1:0] stat;

    irq_steer_regs #(
        .N_SRC(N_SRC), .N_OUT(N_OUT), .N_CFG(N_CFG), .AW(AW), .DW(DW)
    ) u_regs (
        .clk    (clk),
        .rst    (rst),
        .we     (reg_we),
        .addr   (reg_addr),
        .wdata  (reg_wdata),
        .rdata  (reg_rdata),
        .stat   (stat),
        .route  (route),
        .act_low(act_low),
        .trig   (trig),
        .clr    (clr_vec),
        .out_en (out_en)
    );

    for (genvar n = 0; n < N_SRC; n++) begin : g_line
        irq_line_cond #(.SYNC_STAGES(SYNC_STAGES)) u_line (
            .clk    (clk),
            .rst    (rst),
            .raw    (irq_in[n]),
            .act_low(act_low[n]),
            .trig   (trig[n]),
            .clr    (clr_vec[n]),
            .pending(pending[n])
        );
        assign src_en[n]   = route[n].en;
        assign lvl_mode[n] = (trig[n] == TRIG_LEVEL);
    end

    irq_steer_fanout #(.N_SRC(N_SRC), .N_OUT(N_OUT)) u_fanout (
        .clk    (clk),
        .rst    (rst),
        .pending(pending),
        .route  (route),
        .out_en (out_en),
        .stat   (stat),
        .irq_out(irq_out)
    );
endmodule

// File: rtl/irq_steer_chk.sv
module irq_steer_chk #(
    parameter int N_SRC = 16,
    parameter int N_OUT = 8
) (
    input logic                        clk,
    input logic                        rst,
    input logic [N_OUT-1:0]            irq_out,
    input logic [N_OUT-1:0]            oen,
    input logic [N_SRC-1:0]            pending,
    input logic [N_SRC-1:0]            lvl,
    input logic [N_SRC-1:0]            clr,
    input logic [N_SRC-1:0]            en,
    input logic [N_OUT-1:0][N_SRC-1:0] stat
);
    logic [N_SRC-1:0][N_OUT-1:0] col;

    always_comb begin
        for (int n = 0; n < N_SRC; n++)
            for (int k = 0; k < N_OUT; k++)
                col[n][k] = stat[k][n];
    end

    assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (irq_out == '0));

    for (genvar k = 0; k < N_OUT; k++) begin : g_out
        assert_out_gate_R6: assert property (@(posedge clk) disable iff (rst)
            irq_out[k] |-> $past(oen[k]));
    end

    for (genvar n = 0; n < N_SRC; n++) begin : g_src
        assert_single_view_R5: assert property (@(posedge clk) disable iff (rst)
            $onehot0(col[n]));
        assert_disabled_silent_R3: assert property (@(posedge clk) disable iff (rst)
            !en[n] |-> (col[n] == '0));
        assert_edge_sticky_R8: assert property (@(posedge clk) disable iff (rst)
            (pending[n] && !clr[n] && !lvl[n]) |=> (pending[n] || lvl[n]));
    end
endmodule

bind irq_steer_top irq_steer_chk #(.N_SRC(N_SRC), .N_OUT(N_OUT)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .irq_out(irq_out),
    .oen    (out_en),
    .pending(pending),
    .lvl    (lvl_mode),
    .clr    (clr_vec),
    .en     (src_en),
    .stat   (stat)
);

// File: tb/test_irq_steer_top.sv
module test_irq_steer_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        we = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [15:0] irq_in = '0;
    logic [7:0]  irq_out;

    int nvec = 0;
    int nbad = 0;

    irq_steer_top i_irq_steer_top (
        .clk      (clk),
        .rst      (rst),
        .reg_we   (we),
        .reg_addr (addr),
        .reg_wdata(wdata),
        .reg_rdata(rdata),
        .irq_in   (irq_in),
        .irq_out  (irq_out)
    );

    always #2ns clk = ~clk;

    typedef struct packed {
        logic        wr;
        logic [7:0]  a;
        logic [31:0] d;
        logic [31:0] e;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 8'h00, 32'h1234_5678, 32'h0},          // R2 routing low
        '{1'b0, 8'h00, 32'h0,         32'h1234_5678},
        '{1'b1, 8'h04, 32'hFEDC_BA98, 32'h0},          // R2 routing high
        '{1'b0, 8'h04, 32'h0,         32'hFEDC_BA98},
        '{1'b1, 8'h0C, 32'hFFFF_FFFF, 32'h0},          // R7 ten config bits
        '{1'b0, 8'h0C, 32'h0,         32'h0000_03FF},
        '{1'b1, 8'h10, 32'hFFFF_FFFF, 32'h0},          // R6 enables at 16..23
        '{1'b0, 8'h10, 32'h0,         32'h00FF_0000},
        '{1'b0, 8'h08, 32'h0,         32'h0},          // R4 clear reads zero
        '{1'b0, 8'h14, 32'h0,         32'h0},          // R12 hole
        '{1'b0, 8'h30, 32'h0,         32'h0},          // R12 past status
        '{1'b0, 8'hFC, 32'h0,         32'h0},          // R12 top
        '{1'b1, 8'h00, 32'h0,         32'h0},
        '{1'b1, 8'h04, 32'h0,         32'h0},
        '{1'b1, 8'h0C, 32'h0,         32'h0},
        '{1'b1, 8'h10, 32'h0,         32'h0}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s: got %08h expected %08h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        we = 1'b1; addr = a; wdata = d;
        @(posedge clk);
        @(negedge clk);
        we = 1'b0; wdata = '0;
    endtask

    task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string tag);
        addr = a;
        #100ps;
        chk(tag, rdata, exp);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #100ps;
        chk("R1 outputs", {24'h0, irq_out}, 32'h0);
        rd_chk(8'h00, 32'h0, "R1 route lo");
        rd_chk(8'h04, 32'h0, "R1 route hi");
        rd_chk(8'h0C, 32'h0, "R1 line cfg");
        rd_chk(8'h10, 32'h0, "R1 out enable");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nbad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset();

        for (int i = 0; i < NV; i++) begin
            if (VECS[i].wr) wr(VECS[i].a, VECS[i].d);
            else begin
                rd_chk(VECS[i].a, VECS[i].e, "R2 R6 R7 R12 table");
                @(negedge clk);
            end
        end

        do_reset();

        // R10 R11 R5: source 7 -> output 3
        wr(8'h00, 32'hB000_0000);
        wr(8'h10, 32'h0008_0000);
        irq_in[7] = 1'b1;
        repeat (2) @(negedge clk);
        rd_chk(8'h24, 32'h0, "R11 not yet");
        @(negedge clk);
        rd_chk(8'h24, 32'h0080_0000, "R5 R10 status");
        chk("R11 pin lags", {24'h0, irq_out}, 32'h0);
        @(negedge clk);
        chk("R11 pin", {24'h0, irq_out}, 32'h08);
        irq_in[7] = 1'b0;
        repeat (5) @(negedge clk);
        rd_chk(8'h24, 32'h0080_0000, "R8 R10 sticky");
        wr(8'h08, 32'hFFFF_FF7F);
        rd_chk(8'h24, 32'h0080_0000, "R4 zero bits ignored");
        wr(8'h08, 32'h0000_0080);
        rd_chk(8'h24, 32'h0, "R4 cleared");
        @(negedge clk);
        chk("R4 pin low", {24'h0, irq_out}, 32'h0);

        // R6 output gate
        irq_in[7] = 1'b1;
        repeat (4) @(negedge clk);
        chk("R6 pin on", {24'h0, irq_out}, 32'h08);
        irq_in[7] = 1'b0;
        wr(8'h10, 32'h0);
        @(negedge clk);
        chk("R6 gated", {24'h0, irq_out}, 32'h0);
        rd_chk(8'h24, 32'h0080_0000, "R6 status kept");
        wr(8'h10, 32'h0008_0000);
        @(negedge clk);
        chk("R6 regated", {24'h0, irq_out}, 32'h08);

        // R3 source enable
        wr(8'h00, 32'h3000_0000);
        for (int j = 0; j < 4; j++) rd_chk(8'h20 + 8'(4 * j), 32'h0, "R3 views empty");
        rd_chk(8'h00, 32'h3000_0000, "R2 readback");
        @(negedge clk);
        chk("R3 pin low", {24'h0, irq_out}, 32'h0);
        wr(8'h00, 32'hB000_0000);
        rd_chk(8'h24, 32'h0080_0000, "R3 restored");
        wr(8'h08, 32'h0000_FFFF);

        // R13 sources 8 and 15 -> output 5
        wr(8'h04, 32'hD000_000D);
        wr(8'h10, 32'h0020_0000);
        irq_in[8] = 1'b1; irq_in[15] = 1'b1;
        repeat (3) @(negedge clk);
        irq_in[8] = 1'b0; irq_in[15] = 1'b0;
        rd_chk(8'h28, 32'h8100_0000, "R2 R5 high sources");
        @(negedge clk);
        chk("R5 pin 5", {24'h0, irq_out}, 32'h20);
        wr(8'h00, 32'h0);
        wr(8'h04, 32'h0);
        rd_chk(8'h28, 32'h0, "R13 all silent");
        @(negedge clk);
        chk("R13 pin low", {24'h0, irq_out}, 32'h0);
        wr(8'h08, 32'h0000_FFFF);

        // R7 R9 configurable lines 1 (low, level) and 2 (low, edge) -> output 0
        wr(8'h00, 32'h0000_0880);
        wr(8'h10, 32'h0001_0000);
        irq_in[2:1] = 2'b11;
        repeat (4) @(negedge clk);
        wr(8'h0C, 32'h0000_001C);
        wr(8'h08, 32'h0000_FFFF);
        rd_chk(8'h20, 32'h0, "R7 high is inactive");
        irq_in[1] = 1'b0;
        repeat (3) @(negedge clk);
        rd_chk(8'h20, 32'h0000_0002, "R7 R9 low level active");
        wr(8'h08, 32'h0000_0002);
        rd_chk(8'h20, 32'h0000_0002, "R9 clear no effect");
        @(negedge clk);
        chk("R9 pin", {24'h0, irq_out}, 32'h01);
        irq_in[1] = 1'b1;
        repeat (3) @(negedge clk);
        rd_chk(8'h20, 32'h0, "R9 follows release");
        irq_in[2] = 1'b0;
        repeat (3) @(negedge clk);
        rd_chk(8'h20, 32'h0000_0004, "R7 falling edge");
        irq_in[2] = 1'b1;
        repeat (4) @(negedge clk);
        rd_chk(8'h20, 32'h0000_0004, "R8 sticky after release");
        wr(8'h08, 32'h0000_0004);
        rd_chk(8'h20, 32'h0, "R4 edge clear");

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end
endmodule